// File: doc/BRIEF.md
# Serial Management Responder

This block is the PHY-side end of a two-wire serial management link. The controller provides a management clock (MDC) and shares one bidirectional data line (MDIO). The block runs entirely in the MDC domain. It samples the line on every rising MDC edge and works out which kind of frame is on the line.

A write frame that carries this PHY's strapped address stores sixteen data bits into one register of an internal bank of thirty-two. A one-cycle strobe reports that write to the rest of the chip. A read frame that carries this PHY's address gets an answer on the shared line: the block hands over the turnaround, drives the register value onto the line, and then releases it.

Frames that are malformed, or that carry another PHY's address, leave no trace. After such a frame the block waits for a fresh preamble.

Top module: `mdio_slv`

## Requirements
- R1: After reset, mdio_oe and wr_stb are low, and every register in the bank reads back as zero.
- R2: A frame is only recognised after at least PRE_MIN consecutive ones (default 32) sampled on MDIO. The first zero after that run is taken as the first start bit. If the run is shorter, the frame is ignored.
- R3: The start field is the two-bit pattern 0 then 1. A zero in place of the second start bit causes the frame to be ignored.
- R4: The two opcode bits that follow the start field select the access: 1 then 0 is a read, and 0 then 1 is a write. The codes 00 and 11 cause the frame to be ignored.
- R5: After the opcode come a 5-bit PHY address and then a 5-bit register address, each sent most significant bit first. If the PHY address differs from phy_addr, the frame produces no write, no strobe and no drive on MDIO.
- R6: In a matching write, two turnaround bits are followed by sixteen data bits, most significant bit first. wr_stb is high for exactly one MDC cycle, starting at the rising edge that samples the last data bit. During that cycle wr_addr carries the register address and wr_data carries the data, and the bank keeps the new value.
- R7: In a matching read, mdio_oe stays low through the first turnaround bit period. From the falling MDC edge that opens the second turnaround bit, the block drives a 0.
- R8: The read data is the addressed register's value, sent most significant bit first. Each bit is launched on the falling MDC edge that opens its bit period.
- R9: mdio_oe drops on the falling MDC edge that follows the last read data bit. It is never high for more than seventeen consecutive falling edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock from the controller |
| rst_n | input | 1 | Asynchronous active-low reset |
| phy_addr | input | 5 | Strapped PHY address of this responder |
| mdio_i | input | 1 | Value seen on the shared data line |
| mdio_o | output | 1 | Value driven onto the data line when enabled |
| mdio_oe | output | 1 | Output enable of the data line driver |
| wr_stb | output | 1 | One-cycle pulse when a write is accepted |
| wr_addr | output | 5 | Register address of the accepted write |
| wr_data | output | 16 | Data of the accepted write |

## Verification
On every cycle, the assertions check four things: the strobe is a single-cycle pulse, the driver is never enabled while a write is reported, a newly enabled driver starts with a zero, and the enable window stays bounded. They also check that a start bit is only ever accepted after a saturated preamble count.

Only the bench's scenarios can show the rest. That covers whether frames with short preambles, bad starts, unused opcodes or foreign addresses are really ignored, and whether read data matches earlier writes bit for bit at the exact falling edges. Those checks use a reference model of the line, period by period.

// File: rtl/mdio_slv_pkg.sv
package mdio_slv_pkg;

   typedef enum logic [2:0] {
      S_PRE,
      S_START,
      S_HDR,
      S_RD_TA,
      S_RD_DATA,
      S_WR_TA,
      S_WR_DATA
   } frame_st_e;

   localparam logic [1:0] OP_READ  = 2'b10;
   localparam logic [1:0] OP_WRITE = 2'b01;

endpackage

// File: rtl/mdio_slv_bank.sv
module mdio_slv_bank #(
   parameter int REG_AW         = 5,
   parameter int DATA_W         = 16,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic              mdc,
   input  logic              rst_n,
   input  logic              we,
   input  logic [REG_AW-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [REG_AW-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << REG_AW;

   logic [DATA_W-1:0] mem [DEPTH];

   generate
      if (CLEAR_ON_RESET) begin : g_clr
         always_ff @(posedge mdc or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (we) begin
               mem[waddr] <= wdata;
            end
         end
      end else begin : g_noclr
         always_ff @(posedge mdc) begin
            if (we) mem[waddr] <= wdata;
         end
      end
   endgenerate

   assign rdata = mem[raddr];

endmodule

// File: rtl/mdio_slv_frame.sv
module mdio_slv_frame
   import mdio_slv_pkg::*;
#(
   parameter int PHY_AW  = 5,
   parameter int REG_AW  = 5,
   parameter int DATA_W  = 16,
   parameter int PRE_MIN = 32
) (
   input  logic              mdc,
   input  logic              rst_n,
   input  logic              mdio_i,
   input  logic [PHY_AW-1:0] phy_addr,
   output logic [REG_AW-1:0] rd_addr,
   input  logic [DATA_W-1:0] rd_data,
   output logic              tx_en,
   output logic              tx_bit,
   output logic              wr_stb,
   output logic [REG_AW-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data
);
   localparam int HDR_W = 2 + PHY_AW + REG_AW;
   localparam int MAXB  = (HDR_W > DATA_W) ? HDR_W : DATA_W;
   localparam int CNT_W = $clog2(MAXB + 1);
   localparam int PRE_W = $clog2(PRE_MIN + 1);

   frame_st_e         st;
   logic [PRE_W-1:0]  ones;
   logic [CNT_W-1:0]  bcnt;
   logic [HDR_W-2:0]  hdr;
   logic [REG_AW-1:0] reg_q;
   logic [DATA_W-1:0] sh;
   logic              stb_q;
   logic [DATA_W-1:0] wd_q;

   logic [HDR_W-1:0]  hdr_nx;
   logic [1:0]        op_nx;
   logic              phy_hit;

   assign hdr_nx  = {hdr, mdio_i};
   assign op_nx   = hdr_nx[HDR_W-1 -: 2];
   assign phy_hit = (hdr_nx[REG_AW +: PHY_AW] == phy_addr);
   assign rd_addr = hdr_nx[REG_AW-1:0];

   always_ff @(posedge mdc or negedge rst_n) begin
      if (!rst_n) begin
         st    <= S_PRE;
         ones  <= '0;
         bcnt  <= '0;
         hdr   <= '0;
         reg_q <= '0;
         sh    <= '0;
         stb_q <= 1'b0;
         wd_q  <= '0;
      end else begin
         stb_q <= 1'b0;
         case (st)
            S_PRE: begin
               if (mdio_i) begin
                  if (ones != PRE_W'(PRE_MIN)) ones <= ones + 1'b1;
               end else begin
                  if (ones == PRE_W'(PRE_MIN)) st <= S_START;
                  ones <= '0;
               end
            end
            S_START: begin
               bcnt <= '0;
               st   <= mdio_i ? S_HDR : S_PRE;
            end
            S_HDR: begin
               hdr  <= hdr_nx[HDR_W-2:0];
               bcnt <= bcnt + 1'b1;
               if (bcnt == CNT_W'(HDR_W - 1)) begin
                  bcnt  <= '0;
                  reg_q <= hdr_nx[REG_AW-1:0];
                  if (phy_hit && op_nx == OP_READ) begin
                     st <= S_RD_TA;
                     sh <= rd_data;
                  end else if (phy_hit && op_nx == OP_WRITE) begin
                     st <= S_WR_TA;
                  end else begin
                     st <= S_PRE;
                  end
               end
            end
            S_RD_TA, S_WR_TA: begin
               bcnt <= bcnt + 1'b1;
               if (bcnt == CNT_W'(1)) begin
                  bcnt <= '0;
                  st   <= (st == S_RD_TA) ? S_RD_DATA : S_WR_DATA;
               end
            end
            S_RD_DATA: begin
               sh   <= {sh[DATA_W-2:0], 1'b0};
               bcnt <= bcnt + 1'b1;
               if (bcnt == CNT_W'(DATA_W - 1)) begin
                  bcnt <= '0;
                  st   <= S_PRE;
               end
            end
            S_WR_DATA: begin
               sh   <= {sh[DATA_W-2:0], mdio_i};
               bcnt <= bcnt + 1'b1;
               if (bcnt == CNT_W'(DATA_W - 1)) begin
                  bcnt  <= '0;
                  stb_q <= 1'b1;
                  wd_q  <= {sh[DATA_W-2:0], mdio_i};
                  st    <= S_PRE;
               end
            end
            default: st <= S_PRE;
         endcase
      end
   end

   assign tx_en   = (st == S_RD_TA && bcnt == CNT_W'(1)) || (st == S_RD_DATA);
   assign tx_bit  = (st == S_RD_DATA) && sh[DATA_W-1];
   assign wr_stb  = stb_q;
   assign wr_addr = reg_q;
   assign wr_data = wd_q;

   // R6: the write strobe lasts exactly one cycle
   a_r6_single_strobe: assert property (@(posedge mdc) disable iff (!rst_n)
      wr_stb |=> !wr_stb);

   // R2: a start bit is only taken after a saturated run of ones
   a_r2_preamble_len: assert property (@(posedge mdc) disable iff (!rst_n)
      (st == S_START) |-> ($past(st) == S_PRE && $past(ones) == PRE_W'(PRE_MIN)));

endmodule

// File: rtl/mdio_slv_drive.sv
module mdio_slv_drive #(
   parameter int DATA_W = 16
) (
   input  logic mdc,
   input  logic rst_n,
   input  logic tx_en,
   input  logic tx_bit,
   output logic mdio_o,
   output logic mdio_oe
);
   localparam int RUN_W = $clog2(DATA_W + 3);

   always_ff @(negedge mdc or negedge rst_n) begin
      if (!rst_n) begin
         mdio_o  <= 1'b0;
         mdio_oe <= 1'b0;
      end else begin
         mdio_o  <= tx_en & tx_bit;
         mdio_oe <= tx_en;
      end
   end

   // checker: count consecutive falling edges with the driver on
   logic [RUN_W-1:0] oe_run;
   always_ff @(negedge mdc or negedge rst_n) begin
      if (!rst_n)       oe_run <= '0;
      else if (mdio_oe) oe_run <= oe_run + 1'b1;
      else              oe_run <= '0;
   end

   // R7: the first driven bit of a read is the turnaround zero
   a_r7_ta_zero: assert property (@(negedge mdc) disable iff (!rst_n)
      $rose(mdio_oe) |-> !mdio_o);

   // R9: the drive window never exceeds turnaround plus data
   a_r9_oe_bounded: assert property (@(negedge mdc) disable iff (!rst_n)
      oe_run <= RUN_W'(DATA_W + 1));

endmodule

// File: rtl/mdio_slv.sv
module mdio_slv #(
   parameter int PHY_AW         = 5,
   parameter int REG_AW         = 5,
   parameter int DATA_W         = 16,
   parameter int PRE_MIN        = 32,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic              mdc,
   input  logic              rst_n,
   input  logic [PHY_AW-1:0] phy_addr,
   input  logic              mdio_i,
   output logic              mdio_o,
   output logic              mdio_oe,
   output logic              wr_stb,
   output logic [REG_AW-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data
);
   generate
      if (DATA_W < 2) begin : g_bad_dw
         $error("mdio_slv: DATA_W must be at least 2");
      end
      if (PHY_AW < 1 || REG_AW < 1) begin : g_bad_aw
         $error("mdio_slv: address widths must be at least 1");
      end
      if (PRE_MIN < 1) begin : g_bad_pre
         $error("mdio_slv: PRE_MIN must be at least 1");
      end
   endgenerate

   logic [REG_AW-1:0] rd_addr;
   logic [DATA_W-1:0] rd_data;
   logic              tx_en;
   logic              tx_bit;

   mdio_slv_frame #(
      .PHY_AW (PHY_AW),
      .REG_AW (REG_AW),
      .DATA_W (DATA_W),
      .PRE_MIN(PRE_MIN)
   ) u_frame (
      .mdc     (mdc),
      .rst_n   (rst_n),
      .mdio_i  (mdio_i),
      .phy_addr(phy_addr),
      .rd_addr (rd_addr),
      .rd_data (rd_data),
      .tx_en   (tx_en),
      .tx_bit  (tx_bit),
      .wr_stb  (wr_stb),
      .wr_addr (wr_addr),
      .wr_data (wr_data)
   );

   mdio_slv_bank #(
      .REG_AW        (REG_AW),
      .DATA_W        (DATA_W),
      .CLEAR_ON_RESET(CLEAR_ON_RESET)
   ) u_bank (
      .mdc  (mdc),
      .rst_n(rst_n),
      .we   (wr_stb),
      .waddr(wr_addr),
      .wdata(wr_data),
      .raddr(rd_addr),
      .rdata(rd_data)
   );

   mdio_slv_drive #(
      .DATA_W(DATA_W)
   ) u_drive (
      .mdc    (mdc),
      .rst_n  (rst_n),
      .tx_en  (tx_en),
      .tx_bit (tx_bit),
      .mdio_o (mdio_o),
      .mdio_oe(mdio_oe)
   );

   // R5: a reported write never coincides with the responder driving the line
   a_r5_no_drive_on_write: assert property (@(posedge mdc) disable iff (!rst_n)
      wr_stb |-> !mdio_oe);

endmodule

// File: tb/mdio_slv_bench.sv
module mdio_slv_bench;
   localparam int CLK_PERIOD = 40;
   localparam int PRE_N      = 32;

   logic        mdc = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  strap = 5'h13;
   logic        ctl_en = 1'b0;
   logic        ctl_b = 1'b1;
   logic        dut_o, dut_oe, wr_stb;
   logic [4:0]  wr_addr;
   logic [15:0] wr_data;
   logic        line;

   int nchk = 0;
   int nfail = 0;
   bit done = 1'b0;
   logic [15:0] ref_mem [32];

   // controller drives, else responder, else pull-up
   assign line = ctl_en ? ctl_b : (dut_oe ? dut_o : 1'b1);

   mdio_slv u_mdio_slv (
      .mdc     (mdc),
      .rst_n   (rst_n),
      .phy_addr(strap),
      .mdio_i  (line),
      .mdio_o  (dut_o),
      .mdio_oe (dut_oe),
      .wr_stb  (wr_stb),
      .wr_addr (wr_addr),
      .wr_data (wr_data)
   );

   always #(CLK_PERIOD/2) mdc = ~mdc;

   task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // per-period reference: controller bit/enable and expected responder view
   bit        q_ce[$];
   bit        q_cb[$];
   bit        q_xoe[$];
   bit        q_xo[$];
   bit        q_xs[$];

   task automatic push(bit ce, bit cb, bit xoe, bit xo, bit xs);
      q_ce.push_back(ce); q_cb.push_back(cb);
      q_xoe.push_back(xoe); q_xo.push_back(xo); q_xs.push_back(xs);
   endtask

   task automatic frame(string tag, int npre, bit [1:0] stp, bit [1:0] op,
                        bit [4:0] phy, bit [4:0] rg, bit [15:0] wd);
      bit ok, is_rd, v_rd, v_wr;
      bit [15:0] rv;
      ok    = (npre >= PRE_N) && (stp == 2'b01) && (phy == strap);
      is_rd = (op == 2'b10);
      v_rd  = ok && is_rd;
      v_wr  = ok && (op == 2'b01);
      rv    = ref_mem[rg];
      q_ce.delete(); q_cb.delete(); q_xoe.delete(); q_xo.delete(); q_xs.delete();
      push(1, 0, 0, 0, 0);
      for (int i = 0; i < npre; i++) push(1, 1, 0, 0, 0);
      push(1, stp[1], 0, 0, 0); push(1, stp[0], 0, 0, 0);
      push(1, op[1], 0, 0, 0);  push(1, op[0], 0, 0, 0);
      for (int i = 4; i >= 0; i--) push(1, phy[i], 0, 0, 0);
      for (int i = 4; i >= 0; i--) push(1, rg[i], 0, 0, 0);
      if (is_rd) begin
         push(0, 1, 0, 0, 0);
         push(0, 1, v_rd, 0, 0);
         for (int i = 15; i >= 0; i--) push(0, 1, v_rd, rv[i], 0);
      end else begin
         push(1, 1, 0, 0, 0); push(1, 0, 0, 0, 0);
         for (int i = 15; i >= 0; i--) push(1, wd[i], 0, 0, 0);
      end
      push(0, 1, 0, 0, v_wr);
      push(0, 1, 0, 0, 0);
      for (int p = 0; p < q_ce.size(); p++) begin
         @(negedge mdc);
         ctl_en = q_ce[p];
         ctl_b  = q_cb[p];
         #(CLK_PERIOD/4);
         chk(tag, "mdio_oe", {15'd0, dut_oe}, {15'd0, q_xoe[p]});
         if (q_xoe[p]) chk(tag, "mdio_o", {15'd0, dut_o}, {15'd0, q_xo[p]});
         chk(tag, "wr_stb", {15'd0, wr_stb}, {15'd0, q_xs[p]});
         if (q_xs[p]) begin
            chk(tag, "wr_addr", {11'd0, wr_addr}, {11'd0, rg});
            chk(tag, "wr_data", wr_data, wd);
         end
      end
      if (v_wr) ref_mem[rg] = wd;
   endtask

   initial begin
      for (int i = 0; i < 32; i++) ref_mem[i] = 16'h0000;
      repeat (3) @(negedge mdc);
      #(CLK_PERIOD/4);
      chk("R1", "reset mdio_oe", {15'd0, dut_oe}, 16'd0);
      chk("R1", "reset wr_stb", {15'd0, wr_stb}, 16'd0);
      @(negedge mdc);
      rst_n = 1'b1;
      // R1: fresh register reads zero; R7 R8 R9 read timing
      frame("R1", 32, 2'b01, 2'b10, 5'h13, 5'd7, 16'h0);
      // R6: write at exact preamble boundary (R2)
      frame("R6", 32, 2'b01, 2'b01, 5'h13, 5'd3, 16'hA5C3);
      frame("R8", 32, 2'b01, 2'b10, 5'h13, 5'd3, 16'h0);
      frame("R6", 40, 2'b01, 2'b01, 5'h13, 5'd31, 16'hFFFF);
      frame("R9", 33, 2'b01, 2'b10, 5'h13, 5'd31, 16'h0);
      frame("R6", 32, 2'b01, 2'b01, 5'h13, 5'd0, 16'h0001);
      frame("R7", 32, 2'b01, 2'b10, 5'h13, 5'd0, 16'h0);
      // R2: short preamble ignored, for write and read
      frame("R2", 31, 2'b01, 2'b01, 5'h13, 5'd3, 16'h1111);
      frame("R2", 20, 2'b01, 2'b10, 5'h13, 5'd3, 16'h0);
      frame("R2", 32, 2'b01, 2'b10, 5'h13, 5'd3, 16'h0);
      // R3: bad start
      frame("R3", 32, 2'b00, 2'b01, 5'h13, 5'd3, 16'h4444);
      // R4: unused opcodes
      frame("R4", 32, 2'b01, 2'b11, 5'h13, 5'd3, 16'h3333);
      frame("R4", 32, 2'b01, 2'b00, 5'h13, 5'd3, 16'h5555);
      // R5: foreign PHY address
      frame("R5", 32, 2'b01, 2'b01, 5'h12, 5'd3, 16'h2222);
      frame("R5", 32, 2'b01, 2'b10, 5'h03, 5'd3, 16'h0);
      frame("R5", 32, 2'b01, 2'b10, 5'h13, 5'd3, 16'h0);
      // R5: changed strap
      strap = 5'h00;
      frame("R5", 32, 2'b01, 2'b01, 5'h00, 5'd5, 16'h8C01);
      frame("R5", 32, 2'b01, 2'b10, 5'h13, 5'd5, 16'h0);
      frame("R8", 32, 2'b01, 2'b10, 5'h00, 5'd5, 16'h0);
      done = 1'b1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         nchk++;
         nfail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", nchk - nfail, nchk);
         $finish;
      end
   end

endmodule